// File: doc/BRIEF.md
# Three-Wire Serial Tuning-Word Receiver

This block takes a control word shifted in over three wires (a data line, a shift clock and a frame enable) and sorts it into three groups of held outputs: four band-select lines, a 15-bit divider ratio with a one-cycle load strobe, and seven feature bits. All three wires are sampled by a fast system clock, synchronised and edge-detected, so the serial clock may run at any rate well below the system clock.

A frame opens on the rising edge of enable. Each field is committed at a fixed serial-clock pulse count, so one receiver accepts 18-, 19- and 34-bit frames: the band bits are taken at the fourth pulse, the full ratio at the nineteenth, and the feature bits at the thirty-fourth. An 18-bit frame is recognised when enable drops right after the eighteenth pulse; its fourteen ratio bits are loaded with the top ratio bit cleared. A frame that stops early commits only the fields whose commit point it has already passed.

Top module: `tuner_serial_rx`

## Requirements
- R1: After reset band_o is 0, feat_o is 0 (reference divide-by-512 selected), ratio_o is 256 and ratio_load_o is 0.
- R2: On the falling edge of the 4th serial clock pulse of a frame, the first four shifted bits are held on band_o; the first shifted bit goes to band_o[3], the fourth to band_o[0].
- R3: On the falling edge of the 19th pulse, the bits of pulses 5 to 19 are loaded into ratio_o, pulse 5 as bit 14 and pulse 19 as bit 0.
- R4: When enable falls after exactly 18 pulses, ratio_o becomes the bits of pulses 5 to 18 as bits 13 down to 0, with bit 14 cleared.
- R5: The bits of pulses 20 to 26 are held on feat_o[6] down to feat_o[0] on the falling edge of the 34th pulse.
- R6: A frame that ends before a commit point leaves that field unchanged: fewer than 4 pulses change nothing, 4 to 17 pulses change only band_o, 19 to 33 pulses leave feat_o unchanged.
- R7: Pulses after the 34th in a frame change no output; the pulse counter stops at 35.
- R8: ratio_load_o is a single system-clock pulse, high in the cycle ratio_o first shows the new value, once per frame of 18 or more pulses; ratio_o changes at no other time.
- R9: While feat_o[4] is 1, band_o[2] follows tst_ref_i and band_o[3] follows tst_div_i; otherwise they show the held band bits.
- R10: Serial clock pulses while enable is low change no output, and each rising edge of enable restarts the pulse count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ser_data | input | 1 | Serial data, sampled on serial clock rise |
| ser_clk | input | 1 | Serial shift clock |
| ser_en | input | 1 | Frame enable, high during a frame |
| tst_ref_i | input | 1 | Reference test frequency routed to band_o[2] in test mode |
| tst_div_i | input | 1 | Halved divider test frequency routed to band_o[3] in test mode |
| band_o | output | 4 | Band-select outputs |
| ratio_o | output | 15 | Held divider ratio |
| ratio_load_o | output | 1 | One-cycle strobe marking a new ratio |
| feat_o | output | 7 | Held feature bits, feat_o[4] is the test-routing bit |

## Verification
The assertions assume each serial clock phase and each gap between an enable edge and a clock edge lasts several system clocks, so no two synchronised edges arrive in one cycle and a falling edge of the serial clock never coincides with the fall of enable. The stimulus keeps every phase at four system clocks, changes data only while the serial clock is low, and drops enable only after the clock has been low for a while. Frame lengths are drawn at random from 0 to 40 pulses, together with fixed cases at 3, 9, 18, 19, 34 and 40 pulses and stray clocks with enable low.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  localparam int BAND_W     = 4;
  localparam int RATIO_W    = 15;
  localparam int FEAT_W     = 7;
  localparam int BAND_AT    = 4;
  localparam int SHORT_AT   = 18;
  localparam int RATIO_AT   = BAND_AT + RATIO_W;
  localparam int FEAT_FIRST = RATIO_AT + 1;
  localparam int FEAT_AT    = 34;
  localparam int CNT_MAX    = FEAT_AT + 1;
  localparam int CNT_W      = $clog2(CNT_MAX + 1);
  localparam int TEST_BIT   = 4;

  function automatic logic [RATIO_W-1:0] f_ratio_full(input logic [RATIO_W-1:0] sr);
    return sr;
  endfunction

  function automatic logic [RATIO_W-1:0] f_ratio_short(input logic [RATIO_W-1:0] sr);
    return {1'b0, sr[RATIO_W-2:0]};
  endfunction

  function automatic logic [BAND_W-1:0] f_band_out(input logic [BAND_W-1:0] band,
                                                   input logic test_on,
                                                   input logic ref_f,
                                                   input logic div_f);
    logic [BAND_W-1:0] o;
    o = band;
    if (test_on) begin
      o[2] = ref_f;
      o[3] = div_f;
    end
    return o;
  endfunction
endpackage

// File: rtl/tsr_sync.sv
module tsr_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] stg [STAGES];
  logic [N-1:0] prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= pin_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stg[STAGES-1];

  assign lvl_o  = stg[STAGES-1];
  assign rise_o = stg[STAGES-1] & ~prev_q;
  assign fall_o = ~stg[STAGES-1] & prev_q;
endmodule

// File: rtl/tsr_frame.sv
module tsr_frame
  import tsr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               d_lvl,
  input  logic               c_rise,
  input  logic               c_fall,
  input  logic               e_lvl,
  input  logic               e_rise,
  input  logic               e_fall,
  output logic               band_evt,
  output logic               ratio_evt,
  output logic               short_evt,
  output logic               feat_evt,
  output logic [RATIO_W-1:0] main_sr,
  output logic [FEAT_W-1:0]  feat_sr
);
  localparam logic [CNT_W-1:0] P_BAND  = CNT_W'(BAND_AT);
  localparam logic [CNT_W-1:0] P_SHORT = CNT_W'(SHORT_AT);
  localparam logic [CNT_W-1:0] P_RATIO = CNT_W'(RATIO_AT);
  localparam logic [CNT_W-1:0] P_FLO   = CNT_W'(FEAT_FIRST - 1);
  localparam logic [CNT_W-1:0] P_FHI   = CNT_W'(FEAT_FIRST - 1 + FEAT_W);
  localparam logic [CNT_W-1:0] P_FEAT  = CNT_W'(FEAT_AT);
  localparam logic [CNT_W-1:0] P_MAX   = CNT_W'(CNT_MAX);

  logic [CNT_W-1:0] cnt;
  logic             take;

  assign take = c_rise & e_lvl & (cnt < P_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      main_sr <= '0;
      feat_sr <= '0;
    end else if (e_rise) begin
      cnt <= '0;
    end else if (take) begin
      cnt <= cnt + 1'b1;
      if (cnt < P_RATIO)
        main_sr <= {main_sr[RATIO_W-2:0], d_lvl};
      if (cnt >= P_FLO && cnt < P_FHI)
        feat_sr <= {feat_sr[FEAT_W-2:0], d_lvl};
    end
  end

  assign band_evt  = c_fall & e_lvl & (cnt == P_BAND);
  assign ratio_evt = c_fall & e_lvl & (cnt == P_RATIO);
  assign feat_evt  = c_fall & e_lvl & (cnt == P_FEAT);
  assign short_evt = e_fall & (cnt == P_SHORT);

  a_r7_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= P_MAX);
  a_r10_idle_clock_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rise && !e_lvl && !e_rise) |=> $stable(cnt));
  a_r7_no_shift_past_end: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == P_MAX && !e_rise) |=> ($stable(main_sr) && $stable(feat_sr)));
endmodule

// File: rtl/tsr_latches.sv
module tsr_latches
  import tsr_pkg::*;
#(
  parameter logic [RATIO_W-1:0] RATIO_POR = RATIO_W'(256)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               band_evt,
  input  logic               ratio_evt,
  input  logic               short_evt,
  input  logic               feat_evt,
  input  logic [RATIO_W-1:0] main_sr,
  input  logic [FEAT_W-1:0]  feat_sr,
  input  logic               tst_ref_i,
  input  logic               tst_div_i,
  output logic [BAND_W-1:0]  band_o,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               ratio_load_o,
  output logic [FEAT_W-1:0]  feat_o
);
  logic [BAND_W-1:0]  band_q;
  logic [RATIO_W-1:0] ratio_q;
  logic [FEAT_W-1:0]  feat_q;
  logic               load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      band_q  <= '0;
      ratio_q <= RATIO_POR;
      feat_q  <= '0;
      load_q  <= 1'b0;
    end else begin
      load_q <= ratio_evt | short_evt;
      if (band_evt)  band_q  <= main_sr[BAND_W-1:0];
      if (ratio_evt) ratio_q <= f_ratio_full(main_sr);
      if (short_evt) ratio_q <= f_ratio_short(main_sr);
      if (feat_evt)  feat_q  <= feat_sr;
    end
  end

  assign band_o       = f_band_out(band_q, feat_q[TEST_BIT], tst_ref_i, tst_div_i);
  assign ratio_o      = ratio_q;
  assign ratio_load_o = load_q;
  assign feat_o       = feat_q;

  a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_load_o |=> !ratio_load_o);
  a_r8_ratio_held: assert property (@(posedge clk) disable iff (!rst_n)
    !ratio_load_o |-> $stable(ratio_o));
  a_r4_top_bit_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    short_evt |=> !ratio_o[RATIO_W-1]);
  a_r2_band_held: assert property (@(posedge clk) disable iff (!rst_n)
    !band_evt |=> $stable(band_q));
  a_r5_feat_held: assert property (@(posedge clk) disable iff (!rst_n)
    !feat_evt |=> $stable(feat_o));
endmodule

// File: rtl/tuner_serial_rx.sv
module tuner_serial_rx
  import tsr_pkg::*;
#(
  parameter int                 SYNC_STAGES = 2,
  parameter logic [RATIO_W-1:0] RATIO_POR   = RATIO_W'(256)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_data,
  input  logic               ser_clk,
  input  logic               ser_en,
  input  logic               tst_ref_i,
  input  logic               tst_div_i,
  output logic [BAND_W-1:0]  band_o,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               ratio_load_o,
  output logic [FEAT_W-1:0]  feat_o
);
  localparam int PINS = 3;

  logic [PINS-1:0]    lvl, rise, fall;
  logic               band_evt, ratio_evt, short_evt, feat_evt;
  logic [RATIO_W-1:0] main_sr;
  logic [FEAT_W-1:0]  feat_sr;

  tsr_sync #(.N(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  ({ser_en, ser_clk, ser_data}),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  tsr_frame u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .d_lvl     (lvl[0]),
    .c_rise    (rise[1]),
    .c_fall    (fall[1]),
    .e_lvl     (lvl[2]),
    .e_rise    (rise[2]),
    .e_fall    (fall[2]),
    .band_evt  (band_evt),
    .ratio_evt (ratio_evt),
    .short_evt (short_evt),
    .feat_evt  (feat_evt),
    .main_sr   (main_sr),
    .feat_sr   (feat_sr)
  );

  tsr_latches #(.RATIO_POR(RATIO_POR)) u_lat (
    .clk          (clk),
    .rst_n        (rst_n),
    .band_evt     (band_evt),
    .ratio_evt    (ratio_evt),
    .short_evt    (short_evt),
    .feat_evt     (feat_evt),
    .main_sr      (main_sr),
    .feat_sr      (feat_sr),
    .tst_ref_i    (tst_ref_i),
    .tst_div_i    (tst_div_i),
    .band_o       (band_o),
    .ratio_o      (ratio_o),
    .ratio_load_o (ratio_load_o),
    .feat_o       (feat_o)
  );

  a_r8_one_commit_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(ratio_evt && short_evt));
endmodule

// File: tb/tuner_serial_rx_tb.sv
module tuner_serial_rx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_data = 1'b0, ser_clk = 1'b0, ser_en = 1'b0;
  logic        tst_ref_i = 1'b0, tst_div_i = 1'b0;
  logic [3:0]  band_o;
  logic [14:0] ratio_o;
  logic        ratio_load_o;
  logic [6:0]  feat_o;

  int checks = 0, errors = 0, loads = 0;
  logic [3:0]  exp_band = 4'd0;
  logic [14:0] exp_ratio = 15'd256;
  logic [6:0]  exp_feat = 7'd0;
  bit done = 0;

  always #10 clk = ~clk;

  tuner_serial_rx u_dut (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
    .ser_en(ser_en), .tst_ref_i(tst_ref_i), .tst_div_i(tst_div_i),
    .band_o(band_o), .ratio_o(ratio_o), .ratio_load_o(ratio_load_o),
    .feat_o(feat_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R8: at every strobe the new ratio must already be visible
  always @(negedge clk) if (rst_n && ratio_load_o) begin
    loads++;
    chk("R8 ratio with strobe", 32'(ratio_o), 32'(exp_ratio));
  end

  // pulse i (1-based) carries vec[40-i]
  function automatic logic pb(input logic [39:0] v, input int i);
    return v[40-i];
  endfunction

  function automatic logic [3:0] band_view(input logic [3:0] b, input logic [6:0] f,
                                           input logic r, input logic d);
    logic [3:0] o = b;
    if (f[4]) begin o[2] = r; o[3] = d; end
    return o;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic send(input logic [39:0] v, input int n);
    int l0;
    logic [14:0] r;
    // expected model
    if (n >= 4) for (int i = 1; i <= 4; i++) exp_band[4-i] = pb(v, i);
    if (n >= 19) begin
      for (int i = 5; i <= 19; i++) r[19-i] = pb(v, i);
      exp_ratio = r;
    end else if (n == 18) begin
      r = '0;
      for (int i = 5; i <= 18; i++) r[18-i] = pb(v, i);
      exp_ratio = r;
    end
    if (n >= 34) for (int i = 20; i <= 26; i++) exp_feat[26-i] = pb(v, i);
    l0 = loads;
    ser_en = 1'b1; wait_clk(8);
    for (int i = 1; i <= n; i++) begin
      ser_data = pb(v, i); wait_clk(4);
      ser_clk = 1'b1; wait_clk(4);
      ser_clk = 1'b0; wait_clk(4);
    end
    ser_en = 1'b0; wait_clk(12);
    tst_ref_i = 1'($urandom); tst_div_i = 1'($urandom);
    @(negedge clk);
    chk($sformatf("R2/R6/R9 band n=%0d", n), 32'(band_o),
        32'(band_view(exp_band, exp_feat, tst_ref_i, tst_div_i)));
    chk($sformatf("R3/R4/R6 ratio n=%0d", n), 32'(ratio_o), 32'(exp_ratio));
    chk($sformatf("R5/R6/R7 feat n=%0d", n), 32'(feat_o), 32'(exp_feat));
    chk($sformatf("R8 strobes n=%0d", n), 32'(loads - l0), (n >= 18) ? 32'd1 : 32'd0);
  endtask

  task automatic stray(input int n);
    for (int i = 0; i < n; i++) begin
      ser_data = 1'($urandom); wait_clk(4);
      ser_clk = 1'b1; wait_clk(4);
      ser_clk = 1'b0; wait_clk(4);
    end
    @(negedge clk);
    chk("R10 band after idle clocks", 32'(band_o),
        32'(band_view(exp_band, exp_feat, tst_ref_i, tst_div_i)));
    chk("R10 ratio after idle clocks", 32'(ratio_o), 32'(exp_ratio));
    chk("R10 feat after idle clocks", 32'(feat_o), 32'(exp_feat));
  endtask

  function automatic logic [39:0] rnd40();
    return {8'($urandom), $urandom};
  endfunction

  initial begin
    void'($urandom(32'h5eed_0817));
    wait_clk(3); rst_n = 1'b1; @(negedge clk);
    chk("R1 band reset", 32'(band_o), 32'd0);
    chk("R1 ratio reset", 32'(ratio_o), 32'd256);
    chk("R1 feat reset", 32'(feat_o), 32'd0);
    chk("R1 strobe reset", 32'(ratio_load_o), 32'd0);
    send(rnd40(), 3);                                  // R6 nothing committed
    send(40'hA5_0000_0000, 9);                         // R6 band only
    send({4'hC, 14'h3FFF, 22'h0}, 18);                 // R4 short frame
    send({4'h3, 15'h7FFF, 21'h0}, 19);                 // R3 full ratio
    send({4'hF, 15'h1234, 7'b0010000, 14'h3FFF}, 34);  // R5 and R9 (T4 set)
    send({4'h0, 15'h0011, 7'b1101011, 14'h2AAA}, 40);  // R7 extra bits ignored
    send(40'd0, 0);                                    // R10 empty frame
    stray(6);                                          // R10
    for (int k = 0; k < 150; k++) begin
      int n = (k % 4 == 0) ? 34 + int'($urandom_range(0, 6)) : int'($urandom_range(0, 40));
      send(rnd40(), n);
      if (k % 25 == 0) stray(3);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_clk(190000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule